// File: doc/BRIEF.md
# Slotted Ring Station Access Engine

This block makes the per-slot medium access decisions for one station on a unidirectional slotted ring where the receiving station frees each slot. Once per slot time it is handed the slot's access-control byte and destination byte. It decides whether the cell is for this station, and so is copied and freed. It also decides whether a passing asynchronous cell is moved into the station's elastic upstream insertion queue. The slot is freed in either case.

It then picks what to put into a free slot: a local synchronous cell, a local asynchronous cell, or the oldest cell of the upstream queue. Synchronous and asynchronous traffic each have their own allocation cycle with an independent counter. The ring controller restarts each cycle through a restart bit in the header. The station keeps a cycle alive by setting that cycle's continue bit while it still wants to send. A timeout counter stops cells from being stranded in the upstream queue while local asynchronous traffic keeps every free slot busy.

Cell payloads and the queue memories sit outside. The block sees only the queue occupancy counts, and it emits one-cycle strobes that tell the datapath to copy, divert or dequeue. The outgoing header is registered and appears one clock after the incoming one.

Top module: `ring_station_mac`

## Requirements
- R1: The access-control byte uses this layout: bit 7 full, bit 6 asynchronous class (1) or synchronous (0), bit 5 synchronous restart, bit 4 synchronous continue, bit 3 asynchronous restart, bit 2 asynchronous continue, bit 1 monitor, bit 0 spare. The outgoing byte and its strobes are valid, with slot_vld_o high, on the clock after the edge that samples slot_vld_i high.
- R2: A full slot whose destination equals node_id_i raises copy_o, and the slot leaves empty unless this station refills it. This applies to both classes.
- R3: A full asynchronous-class slot for another station raises divert_o, and the freed slot counts as one extra upstream cell for this slot's decisions. A full synchronous-class slot for another station passes with its byte unchanged apart from the continue bits, and no transmit strobe is raised.
- R4: A restart bit zeroes that class's allocation counter before the same slot's transmit decision. Both restart bits pass through unchanged.
- R5: A free slot carries a local synchronous cell (tx_sync_o) when the synchronous counter is below sync_lim_i and sync_cnt_i is non-zero. This choice takes priority over both asynchronous sources, and it increments the counter.
- R6: The synchronous continue bit is set when, after this slot's send, the synchronous counter is below its limit and local synchronous cells remain. A continue bit that is already set on input is never cleared.
- R7: A free slot not taken by synchronous traffic carries an upstream cell (tx_up_o) if the upstream queue is non-empty and any of these holds: the timeout is zero, the upstream depth exceeds up_thr_i, the asynchronous allocation is used up, or the local asynchronous queue is empty.
- R8: Otherwise the slot carries a local asynchronous cell (tx_async_o) when allocation remains and async_cnt_i is non-zero, and the asynchronous counter increments. If the upstream queue is non-empty, the timeout decrements.
- R9: Every upstream send reloads the timeout with async_lim_i + 1. After reset the timeout is zero, so the first waiting upstream cell goes at the first chance.
- R10: The asynchronous continue bit is set when the upstream depth after this slot's send exceeds up_thr_i, or when allocation remains and local asynchronous cells remain after this slot's send.
- R11: A slot filled by this station leaves with full set, the class bit of the inserted cell, and monitor cleared. An emptied, unfilled slot leaves with full, class and monitor all clear.
- R12: Clocks without slot_vld_i raise no strobe and change neither counter nor the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_vld_i | input | 1 | Header of a slot present this clock |
| ctl_i | input | 8 | Incoming access-control byte |
| dst_i | input | ADDR_W | Incoming destination address |
| node_id_i | input | ADDR_W | This station's address |
| sync_lim_i | input | LIM_W | Synchronous cells allowed per cycle |
| async_lim_i | input | LIM_W | Asynchronous cells allowed per cycle |
| up_thr_i | input | LIM_W | Upstream queue threshold |
| sync_cnt_i | input | Q_W | Local synchronous queue occupancy |
| async_cnt_i | input | Q_W | Local asynchronous queue occupancy |
| up_cnt_i | input | Q_W | Upstream insertion queue occupancy |
| slot_vld_o | output | 1 | Outgoing header valid |
| ctl_o | output | 8 | Outgoing access-control byte |
| copy_o | output | 1 | Copy the cell to the local receiver |
| divert_o | output | 1 | Push the cell into the upstream queue |
| tx_sync_o | output | 1 | Dequeue and send a local synchronous cell |
| tx_async_o | output | 1 | Dequeue and send a local asynchronous cell |
| tx_up_o | output | 1 | Dequeue and send an upstream cell |

## Verification
Slots are driven as addressed, foreign-synchronous and foreign-asynchronous cells. This separates stripping from diversion and from pass-through, and it shows that a freshly freed slot can be refilled at once. The transmit choice is tried with the upstream depth at, and one above, the threshold, with the allocation used up and with it refreshed by restart bits, and with the local asynchronous queue empty. This isolates each arm of the upstream-versus-local rule. A run of local sends with upstream cells waiting drains the timeout, so the forced upstream send can be told apart from the threshold and allocation triggers. Idle clocks carrying restart bits confirm that no state moves without a valid slot.

// File: rtl/ring_station_pkg.sv
package ring_station_pkg;
  typedef struct packed {
    logic full;
    logic async_cls;
    logic sync_rst;
    logic sync_cont;
    logic async_rst;
    logic async_cont;
    logic mon;
    logic spare;
  } ring_ctl_t;

  localparam int unsigned NUM_CLS = 2;
  localparam int unsigned CLS_SYNC = 0;
  localparam int unsigned CLS_ASYNC = 1;
endpackage

// File: rtl/rs_rx_stage.sv
module rs_rx_stage
  import ring_station_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  ring_ctl_t         ctl_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] node_id_i,
  output logic              copy_o,
  output logic              divert_o,
  output logic              free_o
);
  always_comb begin
    copy_o   = ctl_i.full && (dst_i == node_id_i);
    divert_o = ctl_i.full && !copy_o && ctl_i.async_cls;
    free_o   = !ctl_i.full || copy_o || divert_o;
  end
endmodule

// File: rtl/rs_alloc_ctr.sv
module rs_alloc_ctr #(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             room_o,
  output logic             room_next_o
);
  logic [LIM_W-1:0] cnt_q, cnt_eff, cnt_nx;

  // restart zeroes the count ahead of this slot's decision
  always_comb begin
    cnt_eff     = clr_i ? '0 : cnt_q;
    cnt_nx      = cnt_eff + LIM_W'(inc_i);
    room_o      = cnt_eff < lim_i;
    room_next_o = cnt_nx < lim_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/rs_tx_arb.sv
module rs_tx_arb #(
  parameter int unsigned Q_W   = 13,
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             free_i,
  input  logic             sync_room_i,
  input  logic             async_room_i,
  input  logic             sync_ne_i,
  input  logic             async_ne_i,
  input  logic [Q_W:0]     up_depth_i,
  input  logic [LIM_W-1:0] thr_i,
  input  logic [LIM_W-1:0] async_lim_i,
  output logic             send_sync_o,
  output logic             send_async_o,
  output logic             send_up_o
);
  localparam int unsigned TO_W = LIM_W + 1;

  logic [TO_W-1:0] to_q;
  logic            up_ne, over, up_pick, left;

  always_comb begin
    up_ne        = up_depth_i != '0;
    over         = up_depth_i > (Q_W+1)'(thr_i);
    send_sync_o  = free_i && sync_room_i && sync_ne_i;
    left         = free_i && !send_sync_o;
    up_pick      = up_ne && ((to_q == '0) || over || !async_room_i || !async_ne_i);
    send_up_o    = left && up_pick;
    send_async_o = left && !up_pick && async_room_i && async_ne_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) to_q <= '0;
    else if (step_i) begin
      if (send_up_o)
        to_q <= {1'b0, async_lim_i} + TO_W'(1);
      else if (send_async_o && up_ne && (to_q != '0))
        to_q <= to_q - TO_W'(1);
    end
  end
endmodule

// File: rtl/ring_station_mac.sv
module ring_station_mac
  import ring_station_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LIM_W  = 8,
  parameter int unsigned Q_W    = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_vld_i,
  input  logic [7:0]        ctl_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [ADDR_W-1:0] node_id_i,
  input  logic [LIM_W-1:0]  sync_lim_i,
  input  logic [LIM_W-1:0]  async_lim_i,
  input  logic [LIM_W-1:0]  up_thr_i,
  input  logic [Q_W-1:0]    sync_cnt_i,
  input  logic [Q_W-1:0]    async_cnt_i,
  input  logic [Q_W-1:0]    up_cnt_i,
  output logic              slot_vld_o,
  output logic [7:0]        ctl_o,
  output logic              copy_o,
  output logic              divert_o,
  output logic              tx_sync_o,
  output logic              tx_async_o,
  output logic              tx_up_o
);
  ring_ctl_t  hin, hout;
  logic       copy, divert, free;
  logic       send_sync, send_async, send_up, sent;
  logic [NUM_CLS-1:0] clr, inc, room, room_nx;
  logic [LIM_W-1:0]   lim [NUM_CLS];
  logic [Q_W:0]       up_eff, up_after;

  assign hin = ring_ctl_t'(ctl_i);

  rs_rx_stage #(.ADDR_W(ADDR_W)) u_rx (
    .ctl_i(hin), .dst_i(dst_i), .node_id_i(node_id_i),
    .copy_o(copy), .divert_o(divert), .free_o(free)
  );

  assign clr[CLS_SYNC]  = hin.sync_rst;
  assign clr[CLS_ASYNC] = hin.async_rst;
  assign inc[CLS_SYNC]  = send_sync;
  assign inc[CLS_ASYNC] = send_async;
  assign lim[CLS_SYNC]  = sync_lim_i;
  assign lim[CLS_ASYNC] = async_lim_i;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    rs_alloc_ctr #(.LIM_W(LIM_W)) u_ctr (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(slot_vld_i),
      .clr_i(clr[c]), .inc_i(inc[c]), .lim_i(lim[c]),
      .room_o(room[c]), .room_next_o(room_nx[c])
    );
  end

  // a diverted cell is already in the queue for this slot's choice
  assign up_eff = {1'b0, up_cnt_i} + (Q_W+1)'(divert);

  rs_tx_arb #(.Q_W(Q_W), .LIM_W(LIM_W)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(slot_vld_i), .free_i(free),
    .sync_room_i(room[CLS_SYNC]), .async_room_i(room[CLS_ASYNC]),
    .sync_ne_i(sync_cnt_i != '0), .async_ne_i(async_cnt_i != '0),
    .up_depth_i(up_eff), .thr_i(up_thr_i), .async_lim_i(async_lim_i),
    .send_sync_o(send_sync), .send_async_o(send_async), .send_up_o(send_up)
  );

  always_comb begin
    sent     = send_sync || send_async || send_up;
    up_after = up_eff - (Q_W+1)'(send_up);
    hout     = hin;
    hout.full      = !free || sent;
    hout.async_cls = sent ? (send_async || send_up) : (!free && hin.async_cls);
    hout.mon       = !free && hin.mon;
    hout.sync_cont = hin.sync_cont
                   || (room_nx[CLS_SYNC] && (sync_cnt_i > Q_W'(send_sync)));
    hout.async_cont = hin.async_cont
                   || (up_after > (Q_W+1)'(up_thr_i))
                   || (room_nx[CLS_ASYNC] && (async_cnt_i > Q_W'(send_async)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_vld_o <= 1'b0;
      ctl_o      <= '0;
      copy_o     <= 1'b0;
      divert_o   <= 1'b0;
      tx_sync_o  <= 1'b0;
      tx_async_o <= 1'b0;
      tx_up_o    <= 1'b0;
    end else begin
      slot_vld_o <= slot_vld_i;
      copy_o     <= slot_vld_i && copy;
      divert_o   <= slot_vld_i && divert;
      tx_sync_o  <= slot_vld_i && send_sync;
      tx_async_o <= slot_vld_i && send_async;
      tx_up_o    <= slot_vld_i && send_up;
      if (slot_vld_i) ctl_o <= hout;
    end
  end
endmodule

// File: rtl/ring_station_chk.sv
module ring_station_chk #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slot_vld_i,
  input logic [7:0]        ctl_i,
  input logic [ADDR_W-1:0] dst_i,
  input logic [ADDR_W-1:0] node_id_i,
  input logic              slot_vld_o,
  input logic [7:0]        ctl_o,
  input logic              copy_o,
  input logic              divert_o,
  input logic              tx_sync_o,
  input logic              tx_async_o,
  input logic              tx_up_o
);
  p_latency_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_vld_i |=> slot_vld_o);
  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_vld_i |=> !slot_vld_o);
  p_copy_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_i && ctl_i[7] && (dst_i == node_id_i)) |=> copy_o);
  p_copy_not_divert_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(copy_o && divert_o));
  p_restart_pass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_vld_i |=> (ctl_o[5] == $past(ctl_i[5])) && (ctl_o[3] == $past(ctl_i[3])));
  p_one_source_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_sync_o, tx_async_o, tx_up_o}));
  p_cont_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_i && ctl_i[4]) |=> ctl_o[4]);
  p_cont_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_i && ctl_i[2]) |=> ctl_o[2]);
  p_fill_full_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_sync_o || tx_async_o || tx_up_o) |-> (ctl_o[7] && !ctl_o[1]));
  p_strobe_gated_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (copy_o || divert_o || tx_sync_o || tx_async_o || tx_up_o) |-> slot_vld_o);
endmodule

bind ring_station_mac ring_station_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .slot_vld_i(slot_vld_i), .ctl_i(ctl_i),
  .dst_i(dst_i), .node_id_i(node_id_i), .slot_vld_o(slot_vld_o), .ctl_o(ctl_o),
  .copy_o(copy_o), .divert_o(divert_o), .tx_sync_o(tx_sync_o),
  .tx_async_o(tx_async_o), .tx_up_o(tx_up_o)
);

// File: tb/sim_ring_station_mac.sv
module sim_ring_station_mac;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] F = 8'h80, AC = 8'h40, SR = 8'h20, SC = 8'h10,
                         AR = 8'h08, AN = 8'h04, MON = 8'h02;
  // strobe vector order: copy, divert, tx_sync, tx_async, tx_up
  localparam logic [4:0] S_NONE = 5'b00000, S_CP = 5'b10000, S_SY = 5'b00100,
                         S_AS = 5'b00010, S_UP = 5'b00001;

  logic clk_i = 0, rst_ni = 0, slot_vld_i = 0;
  logic [7:0] ctl_i = 0, dst_i = 0, node_id_i = 8'h05;
  logic [7:0] sync_lim_i = 8'd2, async_lim_i = 8'd2, up_thr_i = 8'd3;
  logic [12:0] sync_cnt_i = 0, async_cnt_i = 0, up_cnt_i = 0;
  logic slot_vld_o, copy_o, divert_o, tx_sync_o, tx_async_o, tx_up_o;
  logic [7:0] ctl_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ring_station_mac u0 (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic slot(logic [7:0] c, logic [7:0] d, int s, int a, int u,
                      string req, logic [7:0] exp_ctl, logic [4:0] exp_stb);
    @(negedge clk_i);
    ctl_i = c; dst_i = d; sync_cnt_i = 13'(s); async_cnt_i = 13'(a); up_cnt_i = 13'(u);
    slot_vld_i = 1;
    @(negedge clk_i);
    slot_vld_i = 0;
    check({req, " vld"}, 32'(slot_vld_o), 32'd1);
    check({req, " ctl"}, 32'(ctl_o), 32'(exp_ctl));
    check({req, " stb"}, 32'({copy_o, divert_o, tx_sync_o, tx_async_o, tx_up_o}),
          32'(exp_stb));
  endtask

  task automatic t_reset;
    check("R1 reset vld", 32'(slot_vld_o), 0);
    check("R1 reset ctl", 32'(ctl_o), 0);
    check("R12 reset stb", 32'({copy_o, divert_o, tx_sync_o, tx_async_o, tx_up_o}), 0);
  endtask

  task automatic t_rx;
    slot(F, 8'h05, 0, 0, 0, "R2 copy addressed", 8'h00, S_CP);
    slot(F | MON, 8'h09, 0, 0, 0, "R3 sync pass", F | MON, S_NONE);
    // diverted cell refills the slot at once since timeout starts at zero
    slot(F | AC, 8'h09, 0, 0, 0, "R3 R9 divert reuse", F | AC, 5'b01001);
  endtask

  task automatic t_sync;
    slot(SR, 0, 3, 0, 0, "R5 R6 sync send", F | SR | SC, S_SY);
    slot(8'h00, 0, 2, 0, 0, "R6 sync at limit", F, S_SY);
    slot(8'h00, 0, 1, 0, 0, "R5 sync exhausted", 8'h00, S_NONE);
    slot(SC, 0, 0, 0, 0, "R6 cont kept", SC, S_NONE);
    slot(SR, 0, 1, 0, 0, "R4 R6 restart last cell", F | SR, S_SY);
  endtask

  task automatic t_async;
    slot(AR, 0, 0, 5, 0, "R8 R10 local async", F | AC | AR | AN, S_AS);
    slot(8'h00, 0, 0, 5, 1, "R8 local over upstream", F | AC, S_AS);
    slot(8'h00, 0, 0, 5, 1, "R7 alloc used", F | AC, S_UP);
    slot(AR, 0, 0, 0, 2, "R7 local empty", F | AC | AR, S_UP);
  endtask

  task automatic t_thresh;
    slot(F, 8'h09, 0, 0, 5, "R10 over threshold", F | AN, S_NONE);
    slot(8'h00, 0, 0, 5, 4, "R7 above threshold", F | AC | AN, S_UP);
    slot(8'h00, 0, 0, 5, 3, "R7 at threshold", F | AC | AN, S_AS);
  endtask

  task automatic t_timeout;
    slot(AR, 0, 0, 5, 1, "R8 timeout dec 1", F | AC | AR | AN, S_AS);
    slot(AR, 0, 0, 5, 1, "R8 timeout dec 2", F | AC | AR | AN, S_AS);
    slot(AR, 0, 0, 5, 1, "R9 timeout expired", F | AC | AR | AN, S_UP);
    slot(AR, 0, 0, 5, 1, "R9 timeout reloaded", F | AC | AR | AN, S_AS);
  endtask

  task automatic t_prio;
    slot(8'h00, 0, 1, 5, 5, "R5 sync first", F | AN, S_SY);
  endtask

  task automatic t_reuse;
    slot(F | AC, 8'h05, 0, 0, 0, "R2 copy async class", 8'h00, S_CP);
    slot(F | SR | MON, 8'h05, 1, 0, 0, "R11 copy and refill", F | SR, 5'b10100);
  endtask

  task automatic t_idle;
    @(negedge clk_i);
    ctl_i = SR | AR; sync_cnt_i = 5; async_cnt_i = 5; up_cnt_i = 5;
    repeat (3) @(negedge clk_i);
    check("R12 idle vld", 32'(slot_vld_o), 0);
    check("R12 idle stb", 32'({copy_o, divert_o, tx_sync_o, tx_async_o, tx_up_o}), 0);
    // sync counter still 1: one send reaches the limit, no continue
    slot(8'h00, 0, 2, 0, 0, "R12 state kept", F, S_SY);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    t_reset();
    t_rx();
    t_sync();
    t_async();
    t_thresh();
    t_timeout();
    t_prio();
    t_reuse();
    t_idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog got=hung exp=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule